// File: doc/BRIEF.md
# Erase-Block Protection State Manager

This block keeps the write-protection state of every erase block in a boot-block flash device whose small blocks sit at the bottom of the address space. Each block carries two bits, a lock bit and a lock-down bit. The command decoder sends single-cycle requests that lock, unlock or lock-down the block that contains a given word address. A write-protect pin decides whether the lock-down bit is enforced.

A second address port answers queries without delay. For the addressed block it gives the block index, the two protection bits, a 16-bit status word as a signature read would return it, and a writable flag. The program/erase sequencer tests the writable flag before it starts an operation. When the flag is low, the status register raises its protection-error bit.

The default layout has eight 4-Kword parameter blocks covering words 000000h to 007FFFh. Above them are 127 main blocks of 32 Kwords each, 135 blocks in all.

Top module: `blk_lock_mgr`

## Requirements
- R1: The block index of a word address is addr[21:12] for addresses below 008000h, giving 0..7, and 7 + addr[21:15] otherwise, giving 8..134. It is output on qryIndex for qryAddr.
- R2: While rst is high, and afterwards until a request changes them, every block reads locked = 1 and lock-down = 0.
- R3: A request with opCode 01h sets the lock bit of the addressed block, unless R6 applies.
- R4: A request with opCode D0h clears the lock bit of the addressed block, unless R6 applies.
- R5: A request with opCode 2Fh sets both the lock bit and the lock-down bit of the addressed block, whatever the level of wrProtect.
- R6: While wrProtect is 0, 01h and D0h requests to a block whose lock-down bit is set leave that block unchanged.
- R7: While wrProtect is 1, 01h and D0h requests act on a locked-down block as on any other block, and its lock-down bit stays set.
- R8: No request clears a lock-down bit. Only rst does.
- R9: qryWritable is 1 only when the queried block has lock = 0, and also has either lock-down = 0 or wrProtect = 1.
- R10: qryStatus bit 0 is the lock bit and bit 1 is the lock-down bit of the queried block. Bits 15..2 are 0.
- R11: A cycle with opValid = 0, or a request with any opCode other than 01h, D0h or 2Fh, changes no block.
- R12: A request sampled at a rising edge shows on the query outputs right after that edge, not before. It changes only the addressed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; stands for the hardware reset |
| wrProtect | input | 1 | Write-protect pin; 0 enforces lock-down, 1 lifts it |
| opValid | input | 1 | One-cycle request strobe |
| opCode | input | 8 | Request code: 01h lock, D0h unlock, 2Fh lock-down |
| opAddr | input | 22 | Word address selecting the target block |
| qryAddr | input | 22 | Word address of the block being queried |
| qryIndex | output | 8 | Block index decoded from qryAddr |
| qryLocked | output | 1 | Lock bit of the queried block |
| qryLockedDown | output | 1 | Lock-down bit of the queried block |
| qryWritable | output | 1 | High when a program or erase of the queried block may proceed |
| qryStatus | output | 16 | Status word of the queried block |

## Verification
The checker tests properties on every cycle. These are the index range, the status-word format, the writable rule, and the rule that a lock-down bit is never cleared while the same block stays under query. It also checks that a frozen block keeps its lock bit while wrProtect is low, that the lock and unlock codes act in the cycle after the strobe, and that the reset state is correct. Some behaviours show only in the bench's scenarios. These are the address-to-index mapping across the whole address space, the claim that a request touches only its target block, the release of a locked-down block when wrProtect goes high, and the clearing of lock-down by reset alone. The bench checks them by sweeping every block after each request pattern.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  localparam logic [7:0] CODE_LOCK   = 8'h01;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;
  localparam logic [7:0] CODE_DOWN   = 8'h2F;

  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
  } lockStrobe_t;

endpackage

// File: rtl/blk_addr_decode.sv
module blk_addr_decode #(
  parameter int ADDR_W      = 22,
  parameter int PARAM_BLKS  = 8,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter int IDX_W       = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] PARAM_TOP = (ADDR_W+1)'(PARAM_BLKS) << PARAM_SHIFT;
  localparam int MAIN_SKIP = (PARAM_BLKS << PARAM_SHIFT) >> MAIN_SHIFT;
  localparam logic [IDX_W-1:0] MAIN_OFF = IDX_W'(PARAM_BLKS - MAIN_SKIP);

  logic inParam;
  logic [IDX_W-1:0] paramIdx;
  logic [IDX_W-1:0] mainIdx;

  assign inParam  = {1'b0, addr} < PARAM_TOP;
  assign paramIdx = IDX_W'(addr >> PARAM_SHIFT);
  assign mainIdx  = IDX_W'(addr >> MAIN_SHIFT) + MAIN_OFF;
  assign idx      = inParam ? paramIdx : mainIdx;

endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
(
  input  logic        opValid,
  input  logic [7:0]  opCode,
  output lockStrobe_t stb
);
  always_comb begin
    stb = '0;
    if (opValid) begin
      unique case (opCode)
        CODE_LOCK:   stb.setLock = 1'b1;
        CODE_UNLOCK: stb.clrLock = 1'b1;
        CODE_DOWN:   stb.setDown = 1'b1;
        default:     stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/blk_lock_dp.sv
module blk_lock_dp
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLKS = 135,
  parameter int IDX_W    = 8,
  parameter int STAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrProtect,
  input  lockStrobe_t       stb,
  input  logic [IDX_W-1:0]  opIdx,
  input  logic [IDX_W-1:0]  qryIdx,
  output logic              qryLocked,
  output logic              qryLockedDown,
  output logic              qryWritable,
  output logic [STAT_W-1:0] qryStatus
);
  logic [NUM_BLKS-1:0] lockedQ;
  logic [NUM_BLKS-1:0] downQ;

  for (genvar i = 0; i < NUM_BLKS; i++) begin : g_blk
    logic lockBit;
    logic downBit;
    logic hit;
    logic frozen;

    assign hit    = (opIdx == IDX_W'(i));
    assign frozen = downBit & ~wrProtect;

    always_ff @(posedge clk) begin
      if (rst) begin
        lockBit <= 1'b1;
        downBit <= 1'b0;
      end else if (hit) begin
        if (stb.setDown) begin
          lockBit <= 1'b1;
          downBit <= 1'b1;
        end else if (!frozen) begin
          if (stb.setLock)      lockBit <= 1'b1;
          else if (stb.clrLock) lockBit <= 1'b0;
        end
      end
    end

    assign lockedQ[i] = lockBit;
    assign downQ[i]   = downBit;
  end

  assign qryLocked     = lockedQ[qryIdx];
  assign qryLockedDown = downQ[qryIdx];
  assign qryWritable   = ~qryLocked & (wrProtect | ~qryLockedDown);
  assign qryStatus     = {{(STAT_W-2){1'b0}}, qryLockedDown, qryLocked};

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int PARAM_BLKS  = 8,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter int STAT_W      = 16,
  localparam int NUM_BLKS   = PARAM_BLKS + (1 << (ADDR_W - MAIN_SHIFT))
                              - ((PARAM_BLKS << PARAM_SHIFT) >> MAIN_SHIFT),
  localparam int IDX_W      = $clog2(NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrProtect,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [ADDR_W-1:0] qryAddr,
  output logic [IDX_W-1:0]  qryIndex,
  output logic              qryLocked,
  output logic              qryLockedDown,
  output logic              qryWritable,
  output logic [STAT_W-1:0] qryStatus
);
  lockStrobe_t      stb;
  logic [IDX_W-1:0] opIdx;

  blk_addr_decode #(.ADDR_W(ADDR_W), .PARAM_BLKS(PARAM_BLKS), .PARAM_SHIFT(PARAM_SHIFT),
                    .MAIN_SHIFT(MAIN_SHIFT), .IDX_W(IDX_W))
    u_opDec (.addr(opAddr), .idx(opIdx));

  blk_addr_decode #(.ADDR_W(ADDR_W), .PARAM_BLKS(PARAM_BLKS), .PARAM_SHIFT(PARAM_SHIFT),
                    .MAIN_SHIFT(MAIN_SHIFT), .IDX_W(IDX_W))
    u_qryDec (.addr(qryAddr), .idx(qryIndex));

  blk_lock_ctrl u_ctrl (.opValid(opValid), .opCode(opCode), .stb(stb));

  blk_lock_dp #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W), .STAT_W(STAT_W)) u_dp (
    .clk(clk), .rst(rst), .wrProtect(wrProtect), .stb(stb), .opIdx(opIdx),
    .qryIdx(qryIndex), .qryLocked(qryLocked), .qryLockedDown(qryLockedDown),
    .qryWritable(qryWritable), .qryStatus(qryStatus)
  );

endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
  parameter int ADDR_W   = 22,
  parameter int IDX_W    = 8,
  parameter int NUM_BLKS = 135,
  parameter int STAT_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wrProtect,
  input logic              opValid,
  input logic [7:0]        opCode,
  input logic [ADDR_W-1:0] opAddr,
  input logic [ADDR_W-1:0] qryAddr,
  input logic [IDX_W-1:0]  qryIndex,
  input logic              qryLocked,
  input logic              qryLockedDown,
  input logic              qryWritable,
  input logic [STAT_W-1:0] qryStatus
);
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    qryIndex < IDX_W'(NUM_BLKS)); // R1
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (qryLocked && !qryLockedDown)); // R2
  AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opValid && opCode == 8'h01 && opAddr == qryAddr
      && (wrProtect || !qryLockedDown)) && $stable(qryAddr)) |-> qryLocked); // R3
  AST_UNLOCK_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opValid && opCode == 8'hD0 && opAddr == qryAddr
      && (wrProtect || !qryLockedDown)) && $stable(qryAddr)) |-> !qryLocked); // R4
  AST_FROZEN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!wrProtect && qryLockedDown)
      && !$past(opValid && opCode == 8'h2F) && $stable(qryAddr)) |-> $stable(qryLocked)); // R6
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(qryLockedDown) && $stable(qryAddr)) |-> qryLockedDown); // R8
  AST_WRITABLE_RULE: assert property (@(posedge clk) disable iff (rst)
    qryWritable == (!qryLocked && (wrProtect || !qryLockedDown))); // R9
  AST_STATUS_WORD: assert property (@(posedge clk) disable iff (rst)
    qryStatus == {{(STAT_W-2){1'b0}}, qryLockedDown, qryLocked}); // R10
endmodule

bind blk_lock_mgr blk_lock_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_BLKS(NUM_BLKS), .STAT_W(STAT_W))
  u_chk (.clk(clk), .rst(rst), .wrProtect(wrProtect), .opValid(opValid), .opCode(opCode),
         .opAddr(opAddr), .qryAddr(qryAddr), .qryIndex(qryIndex), .qryLocked(qryLocked),
         .qryLockedDown(qryLockedDown), .qryWritable(qryWritable), .qryStatus(qryStatus));

// File: tb/blk_lock_mgr_bench.sv
module blk_lock_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 135;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrProtect = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opCode = 8'h00;
  logic [21:0] opAddr = '0;
  logic [21:0] qryAddr = '0;
  logic [7:0]  qryIndex;
  logic        qryLocked, qryLockedDown, qryWritable;
  logic [15:0] qryStatus;

  int  checks = 0;
  int  errors = 0;
  bit  expLock [NB];
  bit  expDown [NB];
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_mgr u_blk_lock_mgr (
    .clk(clk), .rst(rst), .wrProtect(wrProtect), .opValid(opValid), .opCode(opCode),
    .opAddr(opAddr), .qryAddr(qryAddr), .qryIndex(qryIndex), .qryLocked(qryLocked),
    .qryLockedDown(qryLockedDown), .qryWritable(qryWritable), .qryStatus(qryStatus)
  );

  function automatic int baseOf(int b);
    return (b < 8) ? b * 4096 : (b - 7) * 32768;
  endfunction

  function automatic int sizeOf(int b);
    return (b < 8) ? 4096 : 32768;
  endfunction

  function automatic int idxOf(int a);
    return (a < 32768) ? a / 4096 : 7 + a / 32768;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (qryAddr=%0h)", req, act, exp, qryAddr);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++) begin
      expLock[b] = 1'b1;
      expDown[b] = 1'b0;
    end
  endtask

  task automatic doOp(logic [7:0] code, int addr, bit valid);
    int b;
    @(negedge clk);
    opValid = valid;
    opCode  = code;
    opAddr  = 22'(addr);
    @(negedge clk);
    opValid = 1'b0;
    b = idxOf(addr);
    if (valid) begin
      if (code == 8'h2F) begin
        expLock[b] = 1'b1;
        expDown[b] = 1'b1;
      end else if (!(expDown[b] && !wrProtect)) begin
        if (code == 8'h01) expLock[b] = 1'b1;
        else if (code == 8'hD0) expLock[b] = 1'b0;
      end
    end
  endtask

  task automatic scanAll(string req);
    for (int b = 0; b < NB; b++) begin
      qryAddr = 22'(baseOf(b) + 2);
      #1;
      chk(req, qryLocked, expLock[b]);
      chk(req, qryLockedDown, expDown[b]);
      chk({req, " R10"}, qryStatus, {expDown[b], expLock[b]});
      chk({req, " R9"}, qryWritable, !expLock[b] && (wrProtect || !expDown[b]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    #1;
    scanAll("R2");

    // R1: decode at block edges and on a coarse sweep of the whole space
    for (int b = 0; b < NB; b++) begin
      qryAddr = 22'(baseOf(b));
      #1 chk("R1", qryIndex, b);
      qryAddr = 22'(baseOf(b) + sizeOf(b) - 1);
      #1 chk("R1", qryIndex, b);
    end
    for (int a = 0; a < (1 << 22); a += 1024) begin
      qryAddr = 22'(a);
      #1 chk("R1", qryIndex, idxOf(a));
    end

    // R4 / R12: unlock even blocks only
    for (int b = 0; b < NB; b += 2) doOp(8'hD0, baseOf(b) + 17, 1'b1);
    scanAll("R4 R12");

    // R11: dropped strobe and unknown codes
    doOp(8'hD0, baseOf(1), 1'b0);
    doOp(8'h55, baseOf(2), 1'b1);
    doOp(8'hFF, baseOf(3), 1'b1);
    scanAll("R11");

    // R12: the change appears only after the sampling edge
    @(negedge clk);
    qryAddr = 22'(baseOf(4));
    opValid = 1'b1; opCode = 8'h01; opAddr = 22'(baseOf(4) + 5);
    #1 chk("R12 before edge", qryLocked, 0);
    @(posedge clk);
    #1 chk("R12 after edge", qryLocked, 1);
    @(negedge clk);
    opValid = 1'b0;
    expLock[4] = 1'b1;

    // R3
    doOp(8'h01, baseOf(10), 1'b1);
    scanAll("R3");

    // R5: lock-down, including on already unlocked blocks
    doOp(8'h2F, baseOf(2), 1'b1);
    doOp(8'h2F, baseOf(5), 1'b1);
    doOp(8'h2F, baseOf(8), 1'b1);
    doOp(8'h2F, baseOf(134) + 32767, 1'b1);
    scanAll("R5");

    // R6: wrProtect low freezes locked-down blocks
    doOp(8'hD0, baseOf(2), 1'b1);
    doOp(8'hD0, baseOf(134), 1'b1);
    scanAll("R6");

    // R7: wrProtect high lets them change; lock-down stays
    wrProtect = 1'b1;
    #1;
    scanAll("R7 R9");
    doOp(8'hD0, baseOf(2), 1'b1);
    doOp(8'hD0, baseOf(8), 1'b1);
    doOp(8'hD0, baseOf(5), 1'b1);
    doOp(8'h01, baseOf(5), 1'b1);
    scanAll("R7 R8");

    // R9: lowering wrProtect blocks unlocked but locked-down blocks
    wrProtect = 1'b0;
    #1;
    scanAll("R9");
    doOp(8'h01, baseOf(2), 1'b1);
    scanAll("R6 R8");

    // R8: only reset clears lock-down
    doReset();
    #1;
    scanAll("R8 R2");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule